// File: doc/BRIEF.md
# IDE Channel PIO Cycle Controller

This block runs programmed-I/O cycles on one IDE channel. The host I/O bus runs on the same clock as the block. Each host request carries an I/O address. The block checks that address against the channel's command-block window and its single control-block port. When the address falls in one of them and decoding is allowed, the block drives a chip select, a three-bit cable address and a read or write strobe. It then watches the device's ready line and answers the host with a one-clock acknowledge.

A parameter picks the primary or secondary address set. A 16-bit timing register holds four things: the decode enable, the sample-point and recovery fields, and a switch that hands drive 1 its own timing from a separate input pair. The drive in use is the one named by the last device/head write. Decoding needs three conditions together: the channel enable bit, a global I/O-space enable, and a per-channel signal-disable input held low. A device that never becomes ready is cut off by a timeout, which reports an error with the acknowledge.

The host holds its request until it sees the acknowledge and drops it in that same cycle. If the request stays high, the block treats it as the next request.

Top module: `ide_pio_chan`

## Requirements
- R1: With the primary set, host addresses 0x1F0 to 0x1F7 assert `cbl_cs_cmd` with `cbl_addr` equal to the low three address bits. Address 0x3F6 asserts `cbl_cs_ctl` with `cbl_addr` = 6. Any other address (for example 0x1F8, 0x3F7 or 0x170) gets no acknowledge and no strobe.
- R2: An access is claimed only when timing bit 15, `io_space_en` and not `sig_disable` all hold. Otherwise the request gets no acknowledge and no strobe.
- R3: Timing bits 13:12 set the first ready sample N clocks after the strobe rises: 00 gives 5, 01 gives 4, 10 gives 3. With ready already high, the strobe stays high exactly N clocks.
- R4: Sample-point code 11 behaves as 5 clocks.
- R5: After the first sample, the strobe stays high while ready is low. It falls on the first clock edge at which ready is high.
- R6: If ready never rises, the strobe falls after exactly 256 clocks. The acknowledge then comes with `host_err` = 1. A normal completion gives `host_err` = 0.
- R7: Timing bits 9:8 (00, 01, 10, 11 giving 4, 3, 2, 1 clocks) set the minimum number of clocks the strobe stays low before the next strobe.
- R8: A write to command offset 6 stores data bit 4 as the drive select. The new select applies from the next access on. When timing bit 14 is 1 and drive 1 is selected, the sample-point and recovery codes come from `drv1_smp` and `drv1_rcv`. Otherwise they come from the timing register.
- R9: The timing register resets to 0x0000. A `cfg_wr` pulse loads all 16 bits, and `tim_q` shows the stored value.
- R10: `host_ack` is high for one clock per completed access. For a read, `host_rdata` holds the cable data sampled at the completing edge. For a write, `cbl_wdata` carries the host write data while the strobe is high. `cbl_rd` and `cbl_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_space_en | input | 1 | Global I/O-space decode enable |
| sig_disable | input | 1 | Per-channel cable signal disable |
| cfg_wr | input | 1 | Timing register write strobe |
| cfg_wdata | input | 16 | Timing register write data |
| tim_q | output | 16 | Timing register contents |
| drv1_smp | input | 2 | Drive-1 sample-point code |
| drv1_rcv | input | 2 | Drive-1 recovery code |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Host I/O address |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | One-clock completion pulse |
| host_err | output | 1 | Timeout flag, valid with ack |
| host_rdata | output | 16 | Read data, valid with ack |
| cbl_cs_cmd | output | 1 | Command-block chip select |
| cbl_cs_ctl | output | 1 | Control-block chip select |
| cbl_addr | output | 3 | Cable address |
| cbl_rd | output | 1 | Read strobe |
| cbl_wr | output | 1 | Write strobe |
| cbl_wdata | output | 16 | Cable write data |
| cbl_rdata | input | 16 | Cable read data |
| cbl_ready | input | 1 | Device ready line |

## Verification
The bench tries the cycle engine with three ready patterns:
- Ready high from the first strobe clock, so the measured strobe width shows the sample-point code alone.
- Ready delayed past the sample point, which separates the wait extension from the sample point.
- Ready never rising, which exercises the timeout and its error flag.

Back-to-back requests held high across the acknowledge show the recovery gap. Accesses at the edges of the decode windows, and accesses made with each enable missing, show the decode. Switching the drive select and the drive-1 enable shows which timing source the engine uses.

// File: rtl/ide_pio_pkg.sv
// Package: shared constants, types and code translators for the IDE PIO
// channel. Assumes the timing register layout used throughout this block:
// bit 15 decode enable, bit 14 drive-1 timing switch, 13:12 sample code,
// 9:8 recovery code.
package ide_pio_pkg;

    localparam int TIM_W       = 16;
    localparam int TIM_DEC_EN  = 15;
    localparam int TIM_DRV1_EN = 14;
    localparam int TIM_SMP_LO  = 12;
    localparam int TIM_RCV_LO  = 8;
    localparam int CLK_CNT_W   = 3;

    typedef enum logic [0:0] {
        SEQ_IDLE   = 1'b0,
        SEQ_STROBE = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic [CLK_CNT_W-1:0] smp_clks;
        logic [CLK_CNT_W-1:0] rcv_clks;
    } pio_tmg_t;

    // Sample code to clock count; the reserved code falls back to the slowest.
    function automatic logic [CLK_CNT_W-1:0] smp_code_clks(input logic [1:0] code);
        case (code)
            2'b00:   return 3'd5;
            2'b01:   return 3'd4;
            2'b10:   return 3'd3;
            default: return 3'd5;
        endcase
    endfunction

    // Recovery code to idle clock count: 4 minus the code.
    function automatic logic [CLK_CNT_W-1:0] rcv_code_clks(input logic [1:0] code);
        return 3'd4 - {1'b0, code};
    endfunction

endpackage

// File: rtl/ide_addr_decode.sv
// Address decoder: matches a host I/O address against the channel's
// eight-port command window and single control port. Assumes ADDR_W >= 10
// and that the command base is aligned to eight.
module ide_addr_decode #(
    parameter int ADDR_W = 16,
    parameter bit IS_SEC = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dec_ok,
    output logic              hit_cmd,
    output logic              hit_ctl,
    output logic [2:0]        cab_addr
);

    localparam logic [ADDR_W-1:0] CMD_BASE = IS_SEC ? ADDR_W'(16'h0170) : ADDR_W'(16'h01F0);
    localparam logic [ADDR_W-1:0] CTL_PORT = IS_SEC ? ADDR_W'(16'h0376) : ADDR_W'(16'h03F6);

    // Window compare, gated by the combined decode permission.
    always_comb begin
        hit_cmd  = dec_ok && (addr[ADDR_W-1:3] == CMD_BASE[ADDR_W-1:3]);
        hit_ctl  = dec_ok && (addr == CTL_PORT);
        cab_addr = hit_ctl ? 3'd6 : addr[2:0];
    end

endmodule

// File: rtl/ide_timing_sel.sv
// Timing store: holds the channel timing register and the drive select bit,
// and presents the clock counts for the drive now selected. Assumes the
// drive select update pulse comes from an accepted device/head write.
module ide_timing_sel
    import ide_pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [TIM_W-1:0] cfg_wdata,
    input  logic [1:0]       drv1_smp,
    input  logic [1:0]       drv1_rcv,
    input  logic             drv_wr,
    input  logic             drv_bit,
    output logic [TIM_W-1:0] tim_q,
    output logic             dec_en,
    output pio_tmg_t         tmg
);

    logic drv_q;
    logic use_drv1;

    // Register write and drive select capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q <= '0;
            drv_q <= 1'b0;
        end else begin
            if (cfg_wr) tim_q <= cfg_wdata;
            if (drv_wr) drv_q <= drv_bit;
        end
    end

    // Pick the timing source for the drive in use and translate the codes.
    always_comb begin
        use_drv1     = tim_q[TIM_DRV1_EN] && drv_q;
        dec_en       = tim_q[TIM_DEC_EN];
        tmg.smp_clks = use_drv1 ? smp_code_clks(drv1_smp)
                                : smp_code_clks(tim_q[TIM_SMP_LO +: 2]);
        tmg.rcv_clks = use_drv1 ? rcv_code_clks(drv1_rcv)
                                : rcv_code_clks(tim_q[TIM_RCV_LO +: 2]);
    end

endmodule

// File: rtl/ide_pio_seq.sv
// Cycle sequencer: runs one strobe per accepted access, samples ready from
// the programmed point, times out after TMO_CLKS clocks and enforces the
// recovery gap. Assumes TMO_CLKS exceeds the largest sample point (5).
module ide_pio_seq
    import ide_pio_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int TMO_CLKS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_we,
    input  logic              start_cmd,
    input  logic              start_ctl,
    input  logic [2:0]        start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    input  pio_tmg_t          tmg,
    input  logic              cbl_ready,
    input  logic [DATA_W-1:0] cbl_rdata,
    output logic              can_start,
    output logic              cbl_rd,
    output logic              cbl_wr,
    output logic              cbl_cs_cmd,
    output logic              cbl_cs_ctl,
    output logic [2:0]        cbl_addr,
    output logic [DATA_W-1:0] cbl_wdata,
    output logic              host_ack,
    output logic              host_err,
    output logic [DATA_W-1:0] host_rdata
);

    localparam int TMO_W = $clog2(TMO_CLKS);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CLKS - 1);

    seq_state_t           state;
    logic [CLK_CNT_W-1:0] smp_cnt;
    logic [CLK_CNT_W-1:0] rcv_lat;
    logic [TMO_W-1:0]     wt_cnt;
    logic [1:0]           rc_cnt;
    logic                 done_now;

    // Completion condition once the sample point is reached.
    always_comb begin
        done_now  = (state == SEQ_STROBE) && (smp_cnt == '0)
                    && (cbl_ready || (wt_cnt == TMO_LAST));
        can_start = (state == SEQ_IDLE) && (rc_cnt == 2'd0);
    end

    // Strobe, counters and host completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            smp_cnt    <= '0;
            rcv_lat    <= '0;
            wt_cnt     <= '0;
            rc_cnt     <= 2'd0;
            cbl_rd     <= 1'b0;
            cbl_wr     <= 1'b0;
            cbl_cs_cmd <= 1'b0;
            cbl_cs_ctl <= 1'b0;
            cbl_addr   <= 3'd0;
            cbl_wdata  <= '0;
            host_ack   <= 1'b0;
            host_err   <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ack <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (rc_cnt != 2'd0) rc_cnt <= rc_cnt - 2'd1;
                    if (start && can_start) begin
                        state      <= SEQ_STROBE;
                        cbl_rd     <= !start_we;
                        cbl_wr     <= start_we;
                        cbl_cs_cmd <= start_cmd;
                        cbl_cs_ctl <= start_ctl;
                        cbl_addr   <= start_addr;
                        cbl_wdata  <= start_wdata;
                        smp_cnt    <= tmg.smp_clks - 3'd1;
                        rcv_lat    <= tmg.rcv_clks;
                        wt_cnt     <= '0;
                    end
                end
                SEQ_STROBE: begin
                    wt_cnt <= wt_cnt + 1'b1;
                    if (smp_cnt != '0) smp_cnt <= smp_cnt - 3'd1;
                    if (done_now) begin
                        state      <= SEQ_IDLE;
                        cbl_rd     <= 1'b0;
                        cbl_wr     <= 1'b0;
                        cbl_cs_cmd <= 1'b0;
                        cbl_cs_ctl <= 1'b0;
                        host_ack   <= 1'b1;
                        host_err   <= !cbl_ready;
                        if (cbl_rd) host_rdata <= cbl_rdata;
                        rc_cnt     <= 2'(rcv_lat - 3'd1);
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ide_pio_chan.sv
// Channel top: joins the decoder, timing store and sequencer. Assumes the
// host holds host_req until host_ack and drops it in the ack cycle; a
// request still high after ack is taken as the next access.
module ide_pio_chan
    import ide_pio_pkg::*;
#(
    parameter bit IS_SEC   = 1'b0,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int TMO_CLKS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_space_en,
    input  logic              sig_disable,
    input  logic              cfg_wr,
    input  logic [TIM_W-1:0]  cfg_wdata,
    output logic [TIM_W-1:0]  tim_q,
    input  logic [1:0]        drv1_smp,
    input  logic [1:0]        drv1_rcv,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic              host_err,
    output logic [DATA_W-1:0] host_rdata,
    output logic              cbl_cs_cmd,
    output logic              cbl_cs_ctl,
    output logic [2:0]        cbl_addr,
    output logic              cbl_rd,
    output logic              cbl_wr,
    output logic [DATA_W-1:0] cbl_wdata,
    input  logic [DATA_W-1:0] cbl_rdata,
    input  logic              cbl_ready
);

    logic     dec_en;
    logic     dec_ok;
    logic     hit_cmd;
    logic     hit_ctl;
    logic [2:0] cab_addr;
    logic     can_start;
    logic     start;
    logic     drv_wr;
    pio_tmg_t tmg;

    // Two-level decode permission plus the signal disable.
    always_comb begin
        dec_ok = dec_en && io_space_en && !sig_disable;
        start  = host_req && (hit_cmd || hit_ctl);
        drv_wr = start && can_start && host_we && hit_cmd && (host_addr[2:0] == 3'd6);
    end

    ide_addr_decode #(
        .ADDR_W (ADDR_W),
        .IS_SEC (IS_SEC)
    ) i_dec (
        .addr     (host_addr),
        .dec_ok   (dec_ok),
        .hit_cmd  (hit_cmd),
        .hit_ctl  (hit_ctl),
        .cab_addr (cab_addr)
    );

    ide_timing_sel i_tmg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .drv1_smp  (drv1_smp),
        .drv1_rcv  (drv1_rcv),
        .drv_wr    (drv_wr),
        .drv_bit   (host_wdata[4]),
        .tim_q     (tim_q),
        .dec_en    (dec_en),
        .tmg       (tmg)
    );

    ide_pio_seq #(
        .DATA_W   (DATA_W),
        .TMO_CLKS (TMO_CLKS)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_we    (host_we),
        .start_cmd   (hit_cmd),
        .start_ctl   (hit_ctl),
        .start_addr  (cab_addr),
        .start_wdata (host_wdata),
        .tmg         (tmg),
        .cbl_ready   (cbl_ready),
        .cbl_rdata   (cbl_rdata),
        .can_start   (can_start),
        .cbl_rd      (cbl_rd),
        .cbl_wr      (cbl_wr),
        .cbl_cs_cmd  (cbl_cs_cmd),
        .cbl_cs_ctl  (cbl_cs_ctl),
        .cbl_addr    (cbl_addr),
        .cbl_wdata   (cbl_wdata),
        .host_ack    (host_ack),
        .host_err    (host_err),
        .host_rdata  (host_rdata)
    );

endmodule

// File: rtl/ide_pio_chan_chk.sv
// Checker: temporal properties over the channel's ports, bound to the top.
module ide_pio_chan_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_space_en,
    input logic        sig_disable,
    input logic [15:0] tim_q,
    input logic        cbl_rd,
    input logic        cbl_wr,
    input logic        cbl_cs_cmd,
    input logic        cbl_cs_ctl,
    input logic        host_ack
);

    logic strb;
    assign strb = cbl_rd || cbl_wr;

    p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cbl_rd && cbl_wr));

    p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    p_ack_at_strobe_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ack) |-> $fell(strb));

    p_strobe_min_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb) |=> strb ##1 strb);

    p_claim_needs_enables_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb) |-> $past(io_space_en && tim_q[15] && !sig_disable));

    p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        strb |-> ($countones({cbl_cs_cmd, cbl_cs_ctl}) == 1));

    p_tim_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (tim_q == 16'h0000));

endmodule

bind ide_pio_chan ide_pio_chan_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_space_en (io_space_en),
    .sig_disable (sig_disable),
    .tim_q       (tim_q),
    .cbl_rd      (cbl_rd),
    .cbl_wr      (cbl_wr),
    .cbl_cs_cmd  (cbl_cs_cmd),
    .cbl_cs_ctl  (cbl_cs_ctl),
    .host_ack    (host_ack)
);

// File: tb/test_ide_pio_chan.sv
module test_ide_pio_chan;

    localparam int CLK_PERIOD = 10;
    localparam int TMO = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_space_en = 1'b0;
    logic        sig_disable = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] tim_q;
    logic [1:0]  drv1_smp = 2'b00;
    logic [1:0]  drv1_rcv = 2'b00;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [15:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ack;
    logic        host_err;
    logic [15:0] host_rdata;
    logic        cbl_cs_cmd;
    logic        cbl_cs_ctl;
    logic [2:0]  cbl_addr;
    logic        cbl_rd;
    logic        cbl_wr;
    logic [15:0] cbl_wdata;
    logic [15:0] cbl_rdata = 16'h0000;
    logic        cbl_ready = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ide_pio_chan i_ide_pio_chan (
        .clk(clk), .rst_n(rst_n), .io_space_en(io_space_en), .sig_disable(sig_disable),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .tim_q(tim_q),
        .drv1_smp(drv1_smp), .drv1_rcv(drv1_rcv),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_err(host_err), .host_rdata(host_rdata),
        .cbl_cs_cmd(cbl_cs_cmd), .cbl_cs_ctl(cbl_cs_ctl), .cbl_addr(cbl_addr),
        .cbl_rd(cbl_rd), .cbl_wr(cbl_wr), .cbl_wdata(cbl_wdata),
        .cbl_rdata(cbl_rdata), .cbl_ready(cbl_ready)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R9";
    bit    cmp_on = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_busy, m_rd, m_wr, m_cmd, m_ctl, m_ack, m_err, m_lastrd, m_drv;
    int          m_t, m_n, m_r, m_gap;
    logic [2:0]  m_addr;
    logic [15:0] m_tim, m_rdata, m_wdata;
    bit          m_hitc, m_hitl, m_go, m_sel;

    function automatic int smp_n(input logic [1:0] c);
        if (c == 2'b01) return 4;
        if (c == 2'b10) return 3;
        return 5;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_rd = 0; m_wr = 0; m_cmd = 0; m_ctl = 0; m_ack = 0; m_err = 0;
            m_lastrd = 0; m_drv = 0; m_t = 0; m_n = 5; m_r = 1; m_gap = 0;
            m_addr = 0; m_tim = 0; m_rdata = 0; m_wdata = 0;
        end else begin
            m_ack = 0;
            if (m_busy) begin
                m_t++;
                if (m_t >= m_n && (cbl_ready || m_t >= TMO)) begin
                    m_err = !cbl_ready;
                    m_lastrd = m_rd;
                    if (m_rd) m_rdata = cbl_rdata;
                    m_busy = 0; m_rd = 0; m_wr = 0; m_cmd = 0; m_ctl = 0;
                    m_ack = 1;
                    m_gap = m_r - 1;
                end
            end else begin
                m_hitc = (host_addr >= 16'h1F0) && (host_addr <= 16'h1F7);
                m_hitl = (host_addr == 16'h3F6);
                m_go = host_req && (m_hitc || m_hitl) && m_tim[15] && io_space_en
                       && !sig_disable && (m_gap == 0);
                if (m_gap > 0) m_gap--;
                if (m_go) begin
                    m_sel  = m_tim[14] && m_drv;
                    m_n    = m_sel ? smp_n(drv1_smp) : smp_n(m_tim[13:12]);
                    m_r    = 4 - int'(m_sel ? drv1_rcv : m_tim[9:8]);
                    m_busy = 1; m_t = 0;
                    m_rd = !host_we; m_wr = host_we;
                    m_cmd = m_hitc; m_ctl = m_hitl;
                    m_addr = m_hitl ? 3'd6 : host_addr[2:0];
                    m_wdata = host_wdata;
                    if (host_we && m_hitc && host_addr[2:0] == 3'd6) m_drv = host_wdata[4];
                end
            end
            if (cfg_wr) m_tim = cfg_wdata;
        end
    end

    // Compare model and design on every clock, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk({cbl_rd, cbl_wr, cbl_cs_cmd, cbl_cs_ctl, cbl_addr} ==
                {m_rd, m_wr, m_cmd, m_ctl, (m_busy ? m_addr : cbl_addr)},
                cur_tag, "cable strobe/select/addr",
                {cbl_rd, cbl_wr, cbl_cs_cmd, cbl_cs_ctl, cbl_addr},
                {m_rd, m_wr, m_cmd, m_ctl, m_addr});
            chk(host_ack == m_ack, cur_tag, "host_ack", host_ack, m_ack);
            chk(tim_q == m_tim, "R9", "tim_q", tim_q, m_tim);
            if (m_ack) chk(host_err == m_err, "R6", "host_err", host_err, m_err);
            if (m_ack && m_lastrd && !m_err)
                chk(host_rdata == m_rdata, "R10", "host_rdata", host_rdata, m_rdata);
            if (m_wr) chk(cbl_wdata == m_wdata, "R10", "cbl_wdata", cbl_wdata, m_wdata);
        end
    end

    // ---------------- device model and strobe measurement ----------------
    int rdy_delay = 0;
    int hi_cnt = 0, lo_cnt = 0, last_w = 0, last_gap = 0, rises = 0;
    bit prev_s = 0;
    logic [4:0] last_sel;

    always @(negedge clk) begin
        if (cbl_rd || cbl_wr) begin
            if (!prev_s) begin last_gap = lo_cnt; hi_cnt = 0; rises++; end
            hi_cnt++;
            last_sel = {cbl_cs_cmd, cbl_cs_ctl, cbl_addr};
        end else begin
            if (prev_s) begin last_w = hi_cnt; lo_cnt = 0; end
            lo_cnt++;
        end
        prev_s = cbl_rd || cbl_wr;
        cbl_ready = (cbl_rd || cbl_wr) && (hi_cnt >= rdy_delay);
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic set_tim(input logic [15:0] v);
        cfg_wdata = v; cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0;
        tick();
    endtask

    task automatic access(input logic [15:0] a, input bit we, input logic [15:0] d,
                          input string tag, output bit acked, output bit err);
        acked = 0; err = 0;
        host_addr = a; host_we = we; host_wdata = d; host_req = 1'b1;
        for (int i = 0; i < 400; i++) begin
            tick();
            if (host_ack) begin acked = 1; err = host_err; break; end
        end
        host_req = 1'b0;
        chk(acked, tag, "access acknowledged", acked, 1);
        tick();
        tick();
        tick();
        tick();
        tick();
    endtask

    task automatic no_access(input logic [15:0] a, input string tag);
        int r0;
        int acks;
        r0 = rises; acks = 0;
        host_addr = a; host_we = 1'b0; host_req = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (host_ack) acks++;
        end
        host_req = 1'b0;
        tick();
        chk(acks == 0, tag, "unclaimed access ack count", acks, 0);
        chk(rises == r0, tag, "unclaimed access strobe count", rises - r0, 0);
    endtask

    task automatic pair(input logic [15:0] a1, input logic [15:0] a2, input string tag);
        int got;
        got = 0;
        host_addr = a1; host_we = 1'b0; host_req = 1'b1;
        for (int i = 0; i < 400 && got < 2; i++) begin
            tick();
            if (host_ack) begin got++; host_addr = a2; end
        end
        host_req = 1'b0;
        chk(got == 2, tag, "both accesses acknowledged", got, 2);
        tick();
        tick();
        tick();
        tick();
        tick();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        bit ak;
        bit er;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        cmp_on = 1'b1;

        // R9: reset state
        chk(tim_q == 16'h0000, "R9", "tim_q after reset", tim_q, 0);
        chk(!cbl_rd && !cbl_wr && !host_ack, "R9", "idle outputs after reset",
            {cbl_rd, cbl_wr, host_ack}, 0);

        // R2: each enable missing blocks decode
        cur_tag = "R2";
        io_space_en = 1'b1;
        no_access(16'h01F0, "R2");
        set_tim(16'h8000);
        io_space_en = 1'b0;
        no_access(16'h01F0, "R2");
        io_space_en = 1'b1;
        sig_disable = 1'b1;
        no_access(16'h01F0, "R2");
        sig_disable = 1'b0;

        // R3 / R4: sample point with ready already high
        cur_tag = "R3";
        rdy_delay = 0;
        access(16'h01F0, 0, 0, "R3", ak, er);
        chk(last_w == 5, "R3", "strobe width code 00", last_w, 5);
        set_tim(16'h9000);
        access(16'h01F1, 0, 0, "R3", ak, er);
        chk(last_w == 4, "R3", "strobe width code 01", last_w, 4);
        set_tim(16'hA000);
        access(16'h01F2, 0, 0, "R3", ak, er);
        chk(last_w == 3, "R3", "strobe width code 10", last_w, 3);
        cur_tag = "R4";
        set_tim(16'hB000);
        access(16'h01F3, 0, 0, "R4", ak, er);
        chk(last_w == 5, "R4", "strobe width reserved code", last_w, 5);

        // R5: ready late stretches the strobe
        cur_tag = "R5";
        set_tim(16'hA000);
        rdy_delay = 9;
        access(16'h01F4, 0, 0, "R5", ak, er);
        chk(last_w == 9, "R5", "strobe width with late ready", last_w, 9);
        chk(!er, "R6", "no error on normal completion", er, 0);

        // R6: ready never rises
        cur_tag = "R6";
        rdy_delay = 100000;
        access(16'h01F5, 0, 0, "R6", ak, er);
        chk(last_w == TMO, "R6", "strobe width on timeout", last_w, TMO);
        chk(er, "R6", "error flag on timeout", er, 1);
        rdy_delay = 0;

        // R1 / R10: windows, control port, data paths
        cur_tag = "R1";
        cbl_rdata = 16'hBEEF;
        access(16'h01F7, 0, 0, "R10", ak, er);
        chk(host_rdata == 16'hBEEF, "R10", "read data returned", host_rdata, 16'hBEEF);
        chk(last_sel == 5'b10111, "R1", "select/addr for 0x1F7", last_sel, 5'b10111);
        access(16'h03F6, 1, 16'h5A5A, "R1", ak, er);
        chk(last_sel == 5'b01110, "R1", "select/addr for 0x3F6", last_sel, 5'b01110);
        no_access(16'h01F8, "R1");
        no_access(16'h03F7, "R1");
        no_access(16'h0170, "R1");
        no_access(16'h01EF, "R1");

        // R7: recovery gap between back-to-back strobes
        cur_tag = "R7";
        set_tim(16'hA000);
        pair(16'h01F0, 16'h01F1, "R7");
        chk(last_gap == 4, "R7", "gap for code 00", last_gap, 4);
        set_tim(16'hA200);
        pair(16'h01F0, 16'h01F1, "R7");
        chk(last_gap == 2, "R7", "gap for code 10", last_gap, 2);
        set_tim(16'hA300);
        pair(16'h01F0, 16'h01F1, "R7");
        chk(last_gap == 1, "R7", "gap for code 11", last_gap, 1);

        // R8: per-drive timing
        cur_tag = "R8";
        drv1_smp = 2'b00;
        drv1_rcv = 2'b11;
        set_tim(16'hE000);
        access(16'h01F6, 1, 16'h0010, "R8", ak, er);
        chk(last_w == 3, "R8", "select write uses drive 0 timing", last_w, 3);
        access(16'h01F0, 0, 0, "R8", ak, er);
        chk(last_w == 5, "R8", "drive 1 uses its own timing", last_w, 5);
        set_tim(16'hA000);
        access(16'h01F0, 0, 0, "R8", ak, er);
        chk(last_w == 3, "R8", "switch off shares drive 0 timing", last_w, 3);
        set_tim(16'hE000);
        access(16'h01F6, 1, 16'h0000, "R8", ak, er);
        access(16'h01F0, 0, 0, "R8", ak, er);
        chk(last_w == 3, "R8", "drive 0 uses register timing", last_w, 3);

        // R9: full register write
        cur_tag = "R9";
        set_tim(16'h1234);
        chk(tim_q == 16'h1234, "R9", "tim_q readback", tim_q, 16'h1234);
        no_access(16'h01F0, "R2");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule